// File: doc/BRIEF.md
# Power-On Configuration Loader

After reset is released, this block reads a configuration image from an embedded nonvolatile word store without waiting for any command. It moves the image one bit per clock through a serial shift chain. Each time a full frame has been shifted in, it copies the chain into that frame's volatile configuration latches. Every latch output drives one control point of the programmable fabric, such as a routing pass-gate select, a register enable or a logic clear. A different stored image therefore gives the fabric a different function.

The image has three parts. The first word is a fixed sync pattern. The second word gives the number of frames. The frame payload words follow. A wrong sync pattern or an out-of-range frame count stops the load and raises the error flag, and every configuration output stays cleared. The user logic of the fabric is held in reset until every frame named in the header has been committed. The design therefore never shows a partly configured state.

Top module: `cfg_loader`

## Requirements
- R1: No start command is needed. Counting cycle 1 as the first clock after the synchronous reset `rst` is sampled low, the block asserts `mem_rd` at addresses 0, 1 and 2 in cycles 1, 2 and 3. Every read goes to the address one above the previous read. The store returns the word on `mem_rdata` one cycle after the read.
- R2: The word at address 0 must equal `SYNC_WORD` (default 0xA5). If it differs, `err` rises in cycle 3 and no further read is made.
- R3: The word at address 1 is the frame count N. If N exceeds `NUM_FRAMES`, `err` rises in cycle 4 and nothing is shifted.
- R4: Frame f is made of the words at addresses 2+f*W .. 2+f*W+W-1, where W = FRAME_BITS/WORD_W. The frame value is their concatenation with the lowest-address word in the most significant bits. Bits leave on `chain_data`, most significant bit first, with `chain_en` high. Shifting runs in cycles 4 .. 3+N*FRAME_BITS with no idle cycle between words or frames.
- R5: `frame_wr[f]` is a one-cycle pulse in cycle 4+(f+1)*FRAME_BITS, right after the last bit of frame f. `cfg_bits[f*FRAME_BITS +: FRAME_BITS]` shows the frame value from the next cycle onward. At most one strobe bit is high in any cycle.
- R6: `done` rises in cycle 5+N*FRAME_BITS. When N=0 this is cycle 5, and no strobe or shift occurs.
- R7: Reset clears every bit of `cfg_bits`. The slices of frames with index N or above stay zero. After an error, all of `cfg_bits` stays zero.
- R8: `fabric_rst` is high whenever `done` is low, and it is high during every shift cycle.
- R9: `done` and `err` are never high together. Each one stays high until reset. No memory read is issued once either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Store read address |
| mem_rd | output | 1 | Store read request |
| mem_rdata | input | WORD_W | Store read data, one cycle after request |
| chain_data | output | 1 | Serial bit entering the chain |
| chain_en | output | 1 | Chain shift enable |
| frame_wr | output | NUM_FRAMES | Per-frame latch write strobes |
| cfg_bits | output | NUM_FRAMES*FRAME_BITS | Latch outputs to fabric control points |
| done | output | 1 | All header frames committed |
| err | output | 1 | Sync or count fault |
| fabric_rst | output | 1 | Hold for fabric user logic |

## Verification
All timing is counted from the first clock after reset is released. The reads fall in cycles 1 to 3 and then on every word boundary of the shift phase. Chain bits appear from cycle 4. The strobe for frame f comes in cycle 4+(f+1)*FRAME_BITS, its latch slice changes one cycle later, and done rises in cycle 5+N*FRAME_BITS. The bench keeps a cycle counter and samples every output shortly after each rising edge. It compares each output against a value computed for that exact cycle from the header and the payload words it loaded into the store model. This covers every legal frame count, several payload patterns, a bad sync word and two oversized counts.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

    typedef enum logic [2:0] {
        LD_IDLE     = 3'd0,
        LD_SYNC_REQ = 3'd1,
        LD_SYNC_CHK = 3'd2,
        LD_CNT_CHK  = 3'd3,
        LD_SHIFT    = 3'd4,
        LD_FINISH   = 3'd5,
        LD_DONE     = 3'd6,
        LD_FAULT    = 3'd7
    } ld_state_e;

    // terminal states never leave without reset
    function automatic logic is_final(input ld_state_e s);
        return (s == LD_DONE) || (s == LD_FAULT);
    endfunction

    // address of the first payload word: sync + count header
    localparam int HDR_WORDS = 2;

endpackage

// File: rtl/cfg_word_fetch.sv
module cfg_word_fetch #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] fdata
);
    logic [ADDR_W-1:0] addr_q;
    logic              pend_q;
    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            pend_q <= 1'b0;
            hold_q <= '0;
        end else begin
            pend_q <= req;
            if (req) addr_q <= addr_q + ADDR_W'(1);
            if (pend_q) hold_q <= mem_rdata;
        end
    end

    assign mem_addr = addr_q;
    assign mem_rd   = req;
    // bypass fresh read data, otherwise present the held word
    assign fdata    = pend_q ? mem_rdata : hold_q;

    p_addr_step_r1: assert property (@(posedge clk) disable iff (rst)
        $past(req) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: rtl/cfg_chain.sv
module cfg_chain #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic                  shift_bit,
    output logic [FRAME_BITS-1:0] chain_q
);
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else if (shift_en) chain_q <= {chain_q[FRAME_BITS-2:0], shift_bit};
    end

    p_chain_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(shift_en) |-> $stable(chain_q));
endmodule

// File: rtl/cfg_sram_bank.sv
module cfg_sram_bank #(
    parameter int FRAME_BITS = 16,
    parameter int NUM_FRAMES = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_FRAMES-1:0]            wr,
    input  logic [FRAME_BITS-1:0]            frame_in,
    output logic [NUM_FRAMES*FRAME_BITS-1:0] cfg_out
);
    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic [FRAME_BITS-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) cell_q <= '0;
            else if (wr[i]) cell_q <= frame_in;
        end
        assign cfg_out[i*FRAME_BITS +: FRAME_BITS] = cell_q;
    end

    p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr));
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_ld_pkg::*;
#(
    parameter int                WORD_W     = 8,
    parameter int                FRAME_BITS = 16,
    parameter int                NUM_FRAMES = 4,
    parameter logic [WORD_W-1:0] SYNC_WORD  = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WORD_W-1:0]     fdata,
    output logic                  fetch_req,
    output logic                  shift_en,
    output logic                  shift_bit,
    output logic [NUM_FRAMES-1:0] commit,
    output logic                  done,
    output logic                  err
);
    localparam int WPF   = FRAME_BITS / WORD_W;
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int WRD_W = (WPF > 1) ? $clog2(WPF) : 1;
    localparam int CNT_W = $clog2(NUM_FRAMES + 1);

    ld_state_e         state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [WRD_W-1:0]  word_q;
    logic [CNT_W-1:0]  frame_q, nfrm_q;
    logic [WORD_W-1:0] sr_q;
    logic              cmt_q;
    logic [CNT_W-1:0]  cmt_idx_q;

    logic load, last_bit, last_word, last_frame, sync_ok, cnt_ok, cnt_zero;

    assign load       = (state_q == LD_SHIFT) && (bit_q == '0);
    assign last_bit   = bit_q == BIT_W'(WORD_W - 1);
    assign last_word  = word_q == WRD_W'(WPF - 1);
    assign last_frame = frame_q == (nfrm_q - CNT_W'(1));
    assign sync_ok    = fdata == SYNC_WORD;
    assign cnt_ok     = int'(fdata) <= NUM_FRAMES;
    assign cnt_zero   = fdata == '0;

    assign shift_en  = state_q == LD_SHIFT;
    assign shift_bit = load ? fdata[WORD_W-1] : sr_q[WORD_W-1];

    always_comb begin
        fetch_req = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            LD_IDLE:     state_d = LD_SYNC_REQ;
            LD_SYNC_REQ: begin
                fetch_req = 1'b1;
                state_d   = LD_SYNC_CHK;
            end
            LD_SYNC_CHK: begin
                fetch_req = sync_ok;
                state_d   = sync_ok ? LD_CNT_CHK : LD_FAULT;
            end
            LD_CNT_CHK: begin
                fetch_req = cnt_ok && !cnt_zero;
                if (!cnt_ok)      state_d = LD_FAULT;
                else if (cnt_zero) state_d = LD_FINISH;
                else               state_d = LD_SHIFT;
            end
            LD_SHIFT: begin
                fetch_req = load && !(last_word && last_frame);
                if (last_bit && last_word && last_frame) state_d = LD_FINISH;
            end
            LD_FINISH: state_d = LD_DONE;
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LD_IDLE;
            bit_q     <= '0;
            word_q    <= '0;
            frame_q   <= '0;
            nfrm_q    <= '0;
            sr_q      <= '0;
            cmt_q     <= 1'b0;
            cmt_idx_q <= '0;
        end else begin
            state_q <= state_d;
            cmt_q   <= 1'b0;
            if (state_q == LD_CNT_CHK) begin
                nfrm_q  <= fdata[CNT_W-1:0];
                bit_q   <= '0;
                word_q  <= '0;
                frame_q <= '0;
            end
            if (state_q == LD_SHIFT) begin
                sr_q  <= load ? (fdata << 1) : (sr_q << 1);
                bit_q <= last_bit ? '0 : bit_q + BIT_W'(1);
                if (last_bit) begin
                    word_q <= last_word ? '0 : word_q + WRD_W'(1);
                    if (last_word) begin
                        cmt_q     <= 1'b1;
                        cmt_idx_q <= frame_q;
                        frame_q   <= frame_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_cmt
        assign commit[i] = cmt_q && (cmt_idx_q == CNT_W'(i));
    end

    assign done = state_q == LD_DONE;
    assign err  = state_q == LD_FAULT;

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    p_quiet_final_r9: assert property (@(posedge clk) disable iff (rst)
        is_final(state_q) |-> !fetch_req);
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    p_done_after_commit_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !shift_en);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_ld_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                WORD_W     = 8,
    parameter int                FRAME_BITS = 16,
    parameter int                NUM_FRAMES = 4,
    parameter logic [WORD_W-1:0] SYNC_WORD  = 8'hA5
) (
    input  logic                             clk,
    input  logic                             rst,
    output logic [ADDR_W-1:0]                mem_addr,
    output logic                             mem_rd,
    input  logic [WORD_W-1:0]                mem_rdata,
    output logic                             chain_data,
    output logic                             chain_en,
    output logic [NUM_FRAMES-1:0]            frame_wr,
    output logic [NUM_FRAMES*FRAME_BITS-1:0] cfg_bits,
    output logic                             done,
    output logic                             err,
    output logic                             fabric_rst
);
    localparam int WPF       = FRAME_BITS / WORD_W;
    localparam int IMG_WORDS = HDR_WORDS + NUM_FRAMES * WPF;

    if (WPF * WORD_W != FRAME_BITS) begin : g_bad_frame
        initial $fatal(1, "FRAME_BITS must be a multiple of WORD_W");
    end
    if (IMG_WORDS > (1 << ADDR_W)) begin : g_bad_addr
        initial $fatal(1, "ADDR_W too small for the image");
    end

    logic [WORD_W-1:0]     fdata;
    logic                  fetch_req;
    logic [FRAME_BITS-1:0] chain_q;

    cfg_word_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) fetch_i (
        .clk(clk), .rst(rst), .req(fetch_req),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .fdata(fdata)
    );

    cfg_seq #(
        .WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS),
        .NUM_FRAMES(NUM_FRAMES), .SYNC_WORD(SYNC_WORD)
    ) seq_i (
        .clk(clk), .rst(rst), .fdata(fdata), .fetch_req(fetch_req),
        .shift_en(chain_en), .shift_bit(chain_data), .commit(frame_wr),
        .done(done), .err(err)
    );

    cfg_chain #(.FRAME_BITS(FRAME_BITS)) chain_i (
        .clk(clk), .rst(rst), .shift_en(chain_en), .shift_bit(chain_data),
        .chain_q(chain_q)
    );

    cfg_sram_bank #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES)) bank_i (
        .clk(clk), .rst(rst), .wr(frame_wr), .frame_in(chain_q),
        .cfg_out(cfg_bits)
    );

    assign fabric_rst = !done;

    p_fault_clear_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> (cfg_bits == '0));
    p_hold_in_shift_r8: assert property (@(posedge clk) disable iff (rst)
        chain_en |-> fabric_rst);
    p_commit_follows_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (|frame_wr) |-> $past(chain_en));
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
    localparam int AW = 8, WW = 8, FB = 16, NF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0]    mem_addr;
    logic             mem_rd;
    logic [WW-1:0]    mem_rdata;
    logic             chain_data, chain_en, done, err, fabric_rst;
    logic [NF-1:0]    frame_wr;
    logic [NF*FB-1:0] cfg_bits;

    logic [WW-1:0] mem [0:255];
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    cfg_loader dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .chain_data(chain_data), .chain_en(chain_en),
        .frame_wr(frame_wr), .cfg_bits(cfg_bits), .done(done), .err(err),
        .fabric_rst(fabric_rst)
    );

    task automatic check(input string req, input int cyc,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // one load: header sync, header count, payload derived from seed
    task automatic run_case(input logic [7:0] sync, input int cnt, input int seed);
        int fault_cyc, nf, last_cyc;
        bit sync_ok, cnt_ok;
        for (int a = 0; a < 256; a++) mem[a] = 8'((a * 29 + seed * 53 + 7) & 255);
        mem[0] = sync;
        mem[1] = 8'(cnt);
        sync_ok   = (sync == 8'hA5);
        cnt_ok    = (cnt <= NF);
        fault_cyc = !sync_ok ? 3 : (!cnt_ok ? 4 : 0);
        nf        = (fault_cyc == 0) ? cnt : 0;
        last_cyc  = 5 + nf * FB + 6;

        @(negedge clk) rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R7 reset clears latches; R8 hold during reset; R1 idle in reset
        check("R7 reset cfg", 0, 64'(cfg_bits), 64'd0);
        check("R8 reset hold", 0, 64'(fabric_rst), 64'd1);
        check("R9 reset flags", 0, {62'd0, done, err}, 64'd0);
        check("R1 reset no read", 0, {62'd0, mem_rd, chain_en}, 64'd0);
        @(negedge clk) rst = 1'b0;

        for (int k = 1; k <= last_cyc; k++) begin
            logic          e_rd, e_en, e_bit, e_done, e_err;
            logic [AW-1:0] e_addr;
            logic [NF-1:0] e_wr;
            logic [NF*FB-1:0] e_cfg;
            @(posedge clk);
            #1;
            e_rd = 1'b0; e_addr = '0;
            if (k == 1) begin e_rd = 1'b1; e_addr = 8'd0; end
            else if (k == 2) begin e_rd = sync_ok; e_addr = 8'd1; end
            else if (k == 3) begin e_rd = sync_ok && cnt_ok && cnt > 0; e_addr = 8'd2; end
            else if (k < 4 + nf * FB && (k - 4) % WW == 0) begin
                int g = (k - 4) / WW;
                e_rd = (g + 1 < nf * (FB / WW));
                e_addr = 8'(3 + g);
            end
            check("R1 read req", k, 64'(mem_rd), 64'(e_rd));
            if (e_rd) check("R1 read addr", k, 64'(mem_addr), 64'(e_addr));

            e_en = (k >= 4) && (k < 4 + nf * FB);
            check("R4 chain enable", k, 64'(chain_en), 64'(e_en));
            if (e_en) begin
                int s = k - 4;
                e_bit = mem[2 + s / WW][WW - 1 - s % WW];
                check("R4 chain bit", k, 64'(chain_data), 64'(e_bit));
            end

            e_wr = '0;
            for (int f = 0; f < nf; f++)
                if (k == 4 + (f + 1) * FB) e_wr[f] = 1'b1;
            check("R5 strobe", k, 64'(frame_wr), 64'(e_wr));

            e_cfg = '0;
            for (int f = 0; f < nf; f++)
                if (k >= 5 + (f + 1) * FB)
                    e_cfg[f*FB +: FB] = {mem[2 + 2*f], mem[3 + 2*f]};
            check("R5 R7 cfg slice", k, 64'(cfg_bits), 64'(e_cfg));

            e_done = (fault_cyc == 0) && (k >= 5 + nf * FB);
            e_err  = (fault_cyc != 0) && (k >= fault_cyc);
            check("R6 done", k, 64'(done), 64'(e_done));
            check(fault_cyc == 3 ? "R2 err" : "R3 err", k, 64'(err), 64'(e_err));
            check("R8 fabric hold", k, 64'(fabric_rst), 64'(!e_done));
        end
    endtask

    initial begin
        for (int n = 0; n <= NF; n++) run_case(8'hA5, n, 1);
        run_case(8'hA5, 4, 2);
        run_case(8'hA5, 1, 3);
        run_case(8'hA5, 2, 4);
        run_case(8'h5A, 2, 5);   // R2 bad sync
        run_case(8'hA4, 4, 6);   // R2 bad sync, one bit off
        run_case(8'hA5, 5, 7);   // R3 count just above limit
        run_case(8'hA5, 255, 8); // R3 count far above limit
        run_case(8'hA5, 3, 9);   // R7 reset after error, then good load
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule